// File: doc/BRIEF.md
# Interrupt Source Register Bank

This block keeps the interrupt bookkeeping of one peripheral in three word registers on a simple register bus. A pending register captures one-cycle event pulses from the peripheral's hardware, one bit per source. Software acknowledges a source by writing a 1 to its pending bit. A mask register selects which pending bits may raise an interrupt line. A test port lets software raise pending bits without any hardware event, so that interrupt handlers can be exercised. The test port has no storage of its own. A write to it acts as a pulse that lasts only for the write cycle.

Each interrupt line is the AND of its pending and mask bits, registered once before it leaves the block. Hardware events take priority over software acknowledges, so an event that arrives in the same cycle as an acknowledge is kept. Bus reads return their data one cycle after the read strobe.

Top module: `irq_bank`

## Requirements
- R1: After an active-low reset, the pending register, mask register, interrupt lines and read data are all 0.
- R2: A 1 on bit i of `evt_i` during a clock edge sets pending bit i. The bit stays set until software clears it.
- R3: A write to byte address 0x0 (pending) clears each pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R4: The mask register is read/write at byte address 0x4. It changes only on a write to that address. Bits at or above `N_SRC` read as 0.
- R5: A write to byte address 0x8 (test) sets each pending bit whose write-data bit is 1, and write-data bits of 0 have no effect. A read of 0x8 always returns 0.
- R6: `irq_o` in each cycle equals the bitwise AND of the pending and mask registers as they stood one clock earlier.
- R7: When an event and a software clear reach the same pending bit at the same edge, the bit ends up set.
- R8: A read strobe at one edge loads `bus_rdata_o` with the addressed register, zero-extended to `DATA_W`. An unmapped address returns 0. Without a strobe, `bus_rdata_o` holds its value.
- R9: A write to any address other than 0x0, 0x4 and 0x8 changes neither the pending nor the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| evt_i | input | N_SRC | Per-source event pulses |
| irq_o | output | N_SRC | Registered per-source interrupt lines |

## Verification
The bench targets the collision of a hardware event with a software acknowledge on the same bit. A design that lets the clear win would lose that event and leave its interrupt line low. It also writes zeros to the pending and test addresses: a wrong design would either wipe bits or hold a test value, and a later read of 0x8 would come back nonzero. Writes to unmapped and misaligned addresses check decode aliasing, which would show up as a changed mask. Random traffic checks the one-cycle lag of `irq_o` and the read latency against a model every cycle. Either an interrupt line computed combinationally or a read that returns data one cycle too early would be caught.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_TEST = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned OFF_PEND   = 0;
    localparam int unsigned OFF_MASK   = OFF_PEND + WORD_BYTES;
    localparam int unsigned OFF_TEST   = OFF_MASK + WORD_BYTES;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(OFF_TEST);

    always_comb begin
        if (addr_i == A_PEND)      sel_o = SEL_PEND;
        else if (addr_i == A_MASK) sel_o = SEL_MASK;
        else if (addr_i == A_TEST) sel_o = SEL_TEST;
        else                       sel_o = SEL_NONE;
    end
endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic clr_i,
    input  logic force_i,
    input  logic mask_we_i,
    input  logic mask_d_i,
    output logic pend_o,
    output logic mask_o,
    output logic irq_o
);
    logic pend_d;

    // set terms are ORed after the clear, so a set always wins
    always_comb begin
        pend_d = (pend_o & ~clr_i) | evt_i | force_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_o <= 1'b0;
            mask_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            pend_o <= pend_d;
            if (mask_we_i) mask_o <= mask_d_i;
            irq_o  <= pend_o & mask_o;
        end
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              re_i,
    input  reg_sel_e          sel_i,
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [N_SRC-1:0]  mask_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        unique case (sel_i)
            SEL_PEND: rd_d[N_SRC-1:0] = pend_i;
            SEL_MASK: rd_d[N_SRC-1:0] = mask_i;
            SEL_TEST: rd_d = '0;
            SEL_NONE: rd_d = '0;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   rdata_o <= '0;
        else if (re_i) rdata_o <= rd_d;
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [N_SRC-1:0]  evt_i,
    output logic [N_SRC-1:0]  irq_o
);
    generate
        if (N_SRC > DATA_W || N_SRC == 0) begin : g_bad_width
            $error("irq_bank: N_SRC must be between 1 and DATA_W");
        end
    endgenerate

    reg_sel_e          sel;
    logic [N_SRC-1:0]  wd_src;
    logic [N_SRC-1:0]  clr_v;
    logic [N_SRC-1:0]  force_v;
    logic              mask_we;
    logic [N_SRC-1:0]  st_q;
    logic [N_SRC-1:0]  en_q;

    irq_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    assign wd_src  = bus_wdata_i[N_SRC-1:0];
    assign clr_v   = (bus_we_i && sel == SEL_PEND) ? wd_src : '0;
    assign force_v = (bus_we_i && sel == SEL_TEST) ? wd_src : '0;
    assign mask_we = bus_we_i && (sel == SEL_MASK);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        irq_src_slice i_slice (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (evt_i[i]),
            .clr_i     (clr_v[i]),
            .force_i   (force_v[i]),
            .mask_we_i (mask_we),
            .mask_d_i  (wd_src[i]),
            .pend_o    (st_q[i]),
            .mask_o    (en_q[i]),
            .irq_o     (irq_o[i])
        );
    end

    irq_read_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W)) i_rmux (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .re_i    (bus_re_i),
        .sel_i   (sel),
        .pend_i  (st_q),
        .mask_i  (en_q),
        .rdata_o (bus_rdata_o)
    );
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [N_SRC-1:0]  evt_i,
    input logic [N_SRC-1:0]  irq_o,
    input logic [N_SRC-1:0]  st_q,
    input logic [N_SRC-1:0]  en_q
);
    logic             wr_pend, wr_mask, wr_test;
    logic [N_SRC-1:0] clr_req, tst_req;

    assign wr_pend = bus_we_i && (bus_addr_i == ADDR_W'(OFF_PEND));
    assign wr_mask = bus_we_i && (bus_addr_i == ADDR_W'(OFF_MASK));
    assign wr_test = bus_we_i && (bus_addr_i == ADDR_W'(OFF_TEST));
    assign clr_req = wr_pend ? bus_wdata_i[N_SRC-1:0] : '0;
    assign tst_req = wr_test ? bus_wdata_i[N_SRC-1:0] : '0;

    AST_EVT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((st_q & $past(evt_i)) == $past(evt_i))); // R7

    AST_CLEAR_ONLY_ON_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(st_q) & ~st_q & ~$past(clr_req)) == '0)); // R3

    AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_mask |=> $stable(en_q)); // R4

    AST_TEST_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_test |=> ((st_q & $past(tst_req)) == $past(tst_req))); // R5

    AST_IRQ_LAGS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(st_q & en_q))); // R6
endmodule

bind irq_bank irq_bank_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .evt_i       (evt_i),
    .irq_o       (irq_o),
    .st_q        (st_q),
    .en_q        (en_q)
);

// File: tb/test_irq_bank.sv
module test_irq_bank;
    localparam int unsigned N_SRC  = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic              re = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic [N_SRC-1:0]  evt = '0;
    logic [N_SRC-1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [N_SRC-1:0]  m_st = '0, m_en = '0, m_irq = '0;
    logic [DATA_W-1:0] m_rd = '0;

    always #4 clk = ~clk;

    irq_bank #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_irq_bank (
        .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_re_i(re), .bus_rdata_o(rdata),
        .evt_i(evt), .irq_o(irq)
    );

    function automatic logic [DATA_W-1:0] read_val(logic [ADDR_W-1:0] a,
            logic [N_SRC-1:0] st, logic [N_SRC-1:0] en);
        case (a)
            8'h00:   return DATA_W'(st);
            8'h04:   return DATA_W'(en);
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(logic [N_SRC-1:0] e, logic w, logic r,
                       logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        logic [N_SRC-1:0] clr, tst;
        evt = e; we = w; re = r; addr = a; wdata = d;
        @(posedge clk);
        clr = (w && a == 8'h00) ? d[N_SRC-1:0] : '0;
        tst = (w && a == 8'h08) ? d[N_SRC-1:0] : '0;
        if (r) m_rd = read_val(a, m_st, m_en);
        m_irq = m_st & m_en;
        m_st  = (m_st & ~clr) | e | tst;
        if (w && a == 8'h04) m_en = d[N_SRC-1:0];
        @(negedge clk);
        evt = '0; we = 1'b0; re = 1'b0;
        chk("R6", DATA_W'(irq), DATA_W'(m_irq));
        chk("R8", rdata, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", DATA_W'(irq), '0);
        chk("R1", rdata, '0);
        rst_ni = 1'b1;
        @(negedge clk);
        cyc('0, 0, 1, 8'h00, '0); chk("R1", rdata, '0);
        cyc('0, 0, 1, 8'h04, '0); chk("R1", rdata, '0);

        // R2: events latch and stay
        cyc(8'h05, 0, 0, 8'h00, '0);
        cyc('0, 0, 0, 8'h00, '0);
        cyc('0, 0, 1, 8'h00, '0); chk("R2", rdata, 32'h05);

        // R3: write-1 clears, write-0 leaves bits
        cyc('0, 1, 0, 8'h00, 32'h04);
        cyc('0, 0, 1, 8'h00, '0); chk("R3", rdata, 32'h01);
        cyc('0, 1, 0, 8'h00, 32'h00);
        cyc('0, 0, 1, 8'h00, '0); chk("R3", rdata, 32'h01);

        // R4: mask read/write, upper bits read as 0
        cyc('0, 1, 0, 8'h04, 32'hFFFF_FFFF);
        cyc('0, 0, 1, 8'h04, '0); chk("R4", rdata, 32'h0000_00FF);
        cyc('0, 0, 0, 8'h00, '0); chk("R6", DATA_W'(irq), 32'h01);

        // R5: test port forces, zeros ignored, reads 0
        cyc('0, 1, 0, 8'h08, 32'hA0);
        cyc('0, 1, 0, 8'h08, 32'h00);
        cyc('0, 0, 1, 8'h00, '0); chk("R5", rdata, 32'hA1);
        cyc('0, 0, 1, 8'h08, '0); chk("R5", rdata, 32'h0);

        // R7: event and clear on the same bit, event wins
        cyc(8'h02, 1, 0, 8'h00, 32'h02);
        cyc('0, 0, 1, 8'h00, '0); chk("R7", rdata, 32'hA3);
        cyc('0, 1, 0, 8'h00, 32'hFF);
        cyc('0, 0, 1, 8'h00, '0); chk("R3", rdata, 32'h0);

        // R9: unmapped and misaligned writes do nothing
        cyc('0, 1, 0, 8'h0C, 32'hFF);
        cyc('0, 1, 0, 8'h05, 32'h00);
        cyc('0, 0, 1, 8'h00, '0); chk("R9", rdata, 32'h0);
        cyc('0, 0, 1, 8'h04, '0); chk("R9", rdata, 32'hFF);
        cyc('0, 0, 1, 8'h10, '0); chk("R8", rdata, 32'h0);
        cyc('0, 0, 0, 8'h04, '0); chk("R8", rdata, 32'h0);

        // random mix, compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [N_SRC-1:0]  e;
            logic [ADDR_W-1:0] a;
            logic              w;
            e = ($urandom_range(0, 3) == 0) ? N_SRC'($urandom) & N_SRC'($urandom) : '0;
            a = ADDR_W'($urandom_range(0, 4) * 4);
            w = ($urandom_range(0, 2) == 0);
            cyc(e, w, $urandom_range(0, 1) == 1, a, $urandom);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule